// File: doc/BRIEF.md
# Two-Stage Prescaled Watchdog

This block is a watchdog timer driven over a small 32-bit register bus. A fixed base divider turns the bus clock into slow ticks. A selectable power-of-two prescaler then stretches each tick by 1, 2, 4 or 8. Once software arms the timer, stage A counts prescaled ticks up to a programmable limit. When that limit is reached, an early-warning flag is latched and an interrupt can be raised. Stage B then counts a second limit from zero. When stage B expires, it sends a one-cycle reset request to the system reset controller, together with a two-bit code that selects the kind of reset.

Software keeps the timer alive by writing a kick bit, which restarts stage A. Software can stop the timer only while stage A is still running. After stage A has expired, the timer is locked until it either issues its reset request or is kicked. The stage-B flag survives a warm reset, so that after a CPU or software reset, software can tell that the watchdog caused it. Only a full chip reset or a write-one-to-clear removes it.

Top module: `twostage_wdog`

## Requirements
- R1: One prescaled tick lasts 2^BASE_LOG2 × 2^S bus cycles, where S is the scale field CTRL[2:1] (0..3). The count restarts from zero each time stage A is entered.
- R2: Stage A expires after (LA+1) prescaled ticks, where LA is CTRL[7:3]. At that edge, status bit 0 is set. `irq_early` equals status bit 0 AND CTRL[15].
- R3: Stage B starts at zero when stage A expires and expires after (LB+1) prescaled ticks, where LB is CTRL[12:8]. At that edge, status bit 1 is set and `rst_req` is high for exactly one cycle. `irq_final` equals status bit 1 AND CTRL[16]. `rst_kind` always shows CTRL[14:13].
- R4: Clearing the run bit CTRL[0] during stage A stops the timer, and no expiry follows. Clearing it during stage B has no effect, and the reset request still arrives on time.
- R5: Writing 1 to bit 0 at word address 2 (kick) during stage A or stage B restarts stage A from zero. A kick during stage B leaves status bit 0 set.
- R6: The status register at word address 1 is write-one-to-clear. Writing 0 to a bit leaves that bit unchanged.
- R7: `warm_rst` clears the control register, status bit 0 and the timer state, but keeps status bit 1. `rst` clears everything.
- R8: The control register at word address 0 reads back bits [16:0] exactly as written. Bits [31:17] read as 0.
- R9: After a reset request, the timer stays idle while the run bit remains 1. It starts again only after the run bit is cleared and then set again.
- R10: After `rst`, all outputs are 0 and both registers read 0.
- R11: A kick while the timer is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Full chip reset, synchronous, active high |
| warm_rst | input | 1 | Warm (CPU/software) reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 control, 1 status, 2 kick |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_early | output | 1 | Stage-A interrupt |
| irq_final | output | 1 | Stage-B interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset type code sent with the request |

## Verification
The hardest case to reach is the stage-B lockout combined with a kick. The run bit must be cleared after stage A has expired but before stage B ends, and a kick must then land inside stage B while status bit 0 is still set. The bench uses a small base divider and the coarsest scale, so that stage B lasts dozens of cycles. It waits a computed number of cycles past the stage-A expiry, then clears run and kicks. A per-cycle reference model, driven only by elapsed cycle counts, predicts every output along the way.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;

    localparam int LIM_W  = 5;
    localparam int SCL_W  = 2;
    localparam int KIND_W = 2;
    localparam int CTRL_W = 1 + SCL_W + 2 * LIM_W + KIND_W + 2;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_KICK = 2'd2;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUNA = 2'd1,
        WD_RUNB = 2'd2,
        WD_DONE = 2'd3
    } wd_state_e;

    // bit 0 run, [2:1] scale, [7:3] limit A, [12:8] limit B,
    // [14:13] reset kind, [15] irq enable A, [16] irq enable B
    typedef struct packed {
        logic              ien_b;
        logic              ien_a;
        logic [KIND_W-1:0] kind;
        logic [LIM_W-1:0]  lim_b;
        logic [LIM_W-1:0]  lim_a;
        logic [SCL_W-1:0]  scale;
        logic              run;
    } wd_ctrl_t;

    function automatic logic [31:0] ctrl_to_word(input wd_ctrl_t c);
        return {{(32-CTRL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/wd_ticker.sv
module wd_ticker
    import twostage_wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_rst,
    input  logic             active,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);
    localparam int CW = BASE_LOG2 + (1 << SCL_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = (CW'(1) << (BASE_LOG2 + int'(scale))) - CW'(1);
    assign tick = active && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || warm_rst || restart || !active || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // R1: ticks are always separated by at least one idle cycle
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst || warm_rst)
        tick |=> !tick);

endmodule

// File: rtl/wd_phase.sv
module wd_phase
    import twostage_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_rst,
    input  wd_ctrl_t         ctrl,
    input  logic             kick,
    input  logic             tick,
    output logic             active,
    output logic             restart,
    output logic             exp_a,
    output logic             exp_b,
    output logic             rst_req
);
    wd_state_e        st, nxt;
    logic [LIM_W-1:0] tcnt;

    assign active = (st == WD_RUNA) || (st == WD_RUNB);

    always_comb begin
        nxt     = st;
        restart = 1'b0;
        exp_a   = 1'b0;
        exp_b   = 1'b0;
        unique case (st)
            WD_IDLE: if (ctrl.run) begin
                nxt     = WD_RUNA;
                restart = 1'b1;
            end
            WD_RUNA: begin
                if (!ctrl.run) begin
                    nxt = WD_IDLE;
                end else if (kick) begin
                    restart = 1'b1;
                end else if (tick && tcnt >= ctrl.lim_a) begin
                    nxt     = WD_RUNB;
                    restart = 1'b1;
                    exp_a   = 1'b1;
                end
            end
            WD_RUNB: begin
                if (kick) begin
                    nxt     = WD_RUNA;
                    restart = 1'b1;
                end else if (tick && tcnt >= ctrl.lim_b) begin
                    nxt   = WD_DONE;
                    exp_b = 1'b1;
                end
            end
            WD_DONE: if (!ctrl.run) nxt = WD_IDLE;
            default: nxt = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || warm_rst) begin
            st      <= WD_IDLE;
            tcnt    <= '0;
            rst_req <= 1'b0;
        end else begin
            st      <= nxt;
            rst_req <= exp_b;
            if (restart || !active)
                tcnt <= '0;
            else if (tick)
                tcnt <= tcnt + LIM_W'(1);
        end
    end

    // R4: stage B cannot be left except by expiry or a kick
    p_lock_b_r4: assert property (@(posedge clk) disable iff (rst || warm_rst)
        (st == WD_RUNB && !kick) |=> (st == WD_RUNB || st == WD_DONE));

    // R3: reset request lasts one cycle
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst || warm_rst)
        rst_req |=> !rst_req);

    // R9: after the request the timer waits in DONE while run stays set
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst || warm_rst)
        (st == WD_DONE && ctrl.run) |=> st == WD_DONE);

endmodule

// File: rtl/wd_regs.sv
module wd_regs
    import twostage_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        warm_rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    input  logic        exp_a,
    input  logic        exp_b,
    output wd_ctrl_t    ctrl,
    output logic        flag_a,
    output logic        flag_b,
    output logic [31:0] rdata
);
    logic wr_ctrl, wr_stat;
    wire  unused_hi = ^wdata[31:CTRL_W];

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else if (warm_rst) begin
            ctrl   <= '0;
            flag_a <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= wd_ctrl_t'(wdata[CTRL_W-1:0]);
            flag_a <= exp_a || (flag_a && !(wr_stat && wdata[0]));
            flag_b <= exp_b || (flag_b && !(wr_stat && wdata[1]));
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl_to_word(ctrl);
            A_STAT:  rdata = {30'd0, flag_b, flag_a};
            default: rdata = 32'd0;
        endcase
    end

    // R7: a warm reset never drops the stage-B flag
    p_warm_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (warm_rst && flag_b) |=> flag_b);

    // R2: stage-A expiry latches its flag
    p_flag_a_set_r2: assert property (@(posedge clk) disable iff (rst || warm_rst)
        exp_a |=> flag_a);

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 26
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        warm_rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq_early,
    output logic        irq_final,
    output logic        rst_req,
    output logic [1:0]  rst_kind
);
    wd_ctrl_t ctrl;
    logic     flag_a, flag_b;
    logic     kick, tick, active, restart, exp_a, exp_b;

    assign kick = wr_en && (addr == A_KICK) && wdata[0];

    wd_regs u_regs (
        .clk(clk), .rst(rst), .warm_rst(warm_rst),
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .exp_a(exp_a), .exp_b(exp_b),
        .ctrl(ctrl), .flag_a(flag_a), .flag_b(flag_b), .rdata(rdata)
    );

    wd_ticker #(.BASE_LOG2(BASE_LOG2)) u_tick (
        .clk(clk), .rst(rst), .warm_rst(warm_rst),
        .active(active), .restart(restart), .scale(ctrl.scale), .tick(tick)
    );

    wd_phase u_phase (
        .clk(clk), .rst(rst), .warm_rst(warm_rst),
        .ctrl(ctrl), .kick(kick), .tick(tick),
        .active(active), .restart(restart),
        .exp_a(exp_a), .exp_b(exp_b), .rst_req(rst_req)
    );

    assign irq_early = flag_a && ctrl.ien_a;
    assign irq_final = flag_b && ctrl.ien_b;
    assign rst_kind  = ctrl.kind;

    // R3: the stage-B flag is already set when the request leaves
    p_req_flag_r3: assert property (@(posedge clk) disable iff (rst || warm_rst)
        rst_req |-> flag_b);

endmodule

// File: tb/sim_twostage_wdog.sv
module sim_twostage_wdog;
    localparam int BL = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq_early, irq_final, rst_req;
    logic [1:0]  rst_kind;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int req_seen = 0;

    always #5 clk = ~clk;

    twostage_wdog #(.BASE_LOG2(BL)) u0 (
        .clk(clk), .rst(rst), .warm_rst(warm_rst),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_early(irq_early), .irq_final(irq_final),
        .rst_req(rst_req), .rst_kind(rst_kind)
    );

    // reference model: elapsed cycles per stage, 0 idle 1 A 2 B 3 done
    int          m_st = 0;
    int          m_el = 0;
    logic [16:0] m_ctrl = '0;
    logic        m_fa = 0, m_fb = 0, m_req = 0;

    function automatic int per_cycles(input logic [16:0] c);
        return (1 << (BL + int'(c[2:1])));
    endfunction

    always @(posedge clk) begin
        logic kick, sa, sb;
        cycles++;
        kick = wr_en && addr == 2'd2 && wdata[0];
        sa = 0; sb = 0; m_req = 0;
        if (rst) begin
            m_st = 0; m_el = 0; m_ctrl = '0; m_fa = 0; m_fb = 0;
        end else if (warm_rst) begin
            m_st = 0; m_el = 0; m_ctrl = '0; m_fa = 0;
        end else begin
            case (m_st)
                0: if (m_ctrl[0]) begin m_st = 1; m_el = 0; end
                1: if (!m_ctrl[0]) m_st = 0;
                   else if (kick) m_el = 0;
                   else if (m_el + 1 == per_cycles(m_ctrl) * (int'(m_ctrl[7:3]) + 1)) begin
                       m_st = 2; m_el = 0; sa = 1;
                   end else m_el++;
                2: if (kick) begin m_st = 1; m_el = 0; end
                   else if (m_el + 1 == per_cycles(m_ctrl) * (int'(m_ctrl[12:8]) + 1)) begin
                       m_st = 3; sb = 1; m_req = 1;
                   end else m_el++;
                default: if (!m_ctrl[0]) m_st = 0;
            endcase
            m_fa = sa | (m_fa & !(wr_en && addr == 2'd1 && wdata[0]));
            m_fb = sb | (m_fb & !(wr_en && addr == 2'd1 && wdata[1]));
            if (wr_en && addr == 2'd0) m_ctrl = wdata[16:0];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 2 ns after each edge
    always @(posedge clk) begin
        #2;
        if (rst_req) req_seen++;
        chk("R2", "irq_early (tick length R1)", {31'd0, irq_early}, {31'd0, m_fa & m_ctrl[15]});
        chk("R3", "irq_final", {31'd0, irq_final}, {31'd0, m_fb & m_ctrl[16]});
        chk("R3", "rst_req", {31'd0, rst_req}, {31'd0, m_req});
        chk("R3", "rst_kind", {30'd0, rst_kind}, {30'd0, m_ctrl[14:13]});
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, "rdata", rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cw(input int run, input int sc, input int la, input int lb, input int kd);
        return 32'(run) | (32'(sc) << 1) | (32'(la) << 3) | (32'(lb) << 8) | (32'(kd) << 13) | (32'h3 << 15);
    endfunction

    initial begin
        int seen0;
        idle(3);
        rst = 1'b0;
        // R10: reset state
        rd("R10", 2'd0, 32'd0);
        rd("R10", 2'd1, 32'd0);
        chk("R10", "outputs", {28'd0, irq_early, irq_final, rst_req, 1'b0}, 32'd0);

        // R1 R2 R3: scale 0, LA=2, LB=1 -> 12 + 8 cycles
        seen0 = req_seen;
        wr(2'd0, cw(1, 0, 2, 1, 2));
        rd("R8", 2'd0, cw(1, 0, 2, 1, 2));
        idle(40);
        chk("R3", "one request", 32'(req_seen - seen0), 32'd1);
        rd("R2", 2'd1, 32'd3);

        // R6: write-one-to-clear
        wr(2'd1, 32'd0);
        rd("R6", 2'd1, 32'd3);
        wr(2'd1, 32'd1);
        rd("R6", 2'd1, {30'd0, m_fb, m_fa});
        wr(2'd1, 32'd2);
        rd("R6", 2'd1, 32'd0);

        // R9: run still set, no restart
        seen0 = req_seen;
        idle(60);
        chk("R9", "stays idle", 32'(req_seen - seen0), 32'd0);

        // R8: full field readback with odd pattern
        wr(2'd0, 32'hFFFF_FFFE);
        rd("R8", 2'd0, 32'h0001_FFFE);

        // R1: scale 1 and 2
        wr(2'd0, cw(0, 1, 0, 0, 1));
        wr(2'd0, cw(1, 1, 0, 0, 1));
        idle(30);
        wr(2'd0, cw(0, 2, 1, 0, 3));
        wr(2'd1, 32'd3);
        wr(2'd0, cw(1, 2, 1, 0, 3));
        idle(70);
        rd("R1", 2'd1, 32'd3);

        // R4: stop in stage A (scale 3: 32 cycles per tick)
        wr(2'd1, 32'd3);
        wr(2'd0, cw(0, 3, 1, 1, 1));
        wr(2'd0, cw(1, 3, 1, 1, 1));
        idle(30);
        wr(2'd0, cw(0, 3, 1, 1, 1));
        idle(100);
        rd("R4", 2'd1, 32'd0);

        // R5: repeated kicks in stage A prevent expiry
        wr(2'd0, cw(1, 3, 1, 1, 1));
        for (int i = 0; i < 8; i++) begin
            idle(40);
            wr(2'd2, 32'd1);
        end
        rd("R5", 2'd1, 32'd0);

        // R4 lock in stage B, then R5 kick in stage B keeps flag A
        idle(70);
        rd("R2", 2'd1, 32'd1);
        wr(2'd0, cw(0, 3, 1, 1, 1));
        idle(10);
        rd("R4", 2'd1, 32'd1);
        wr(2'd0, cw(1, 3, 1, 1, 1));
        wr(2'd2, 32'd1);
        rd("R5", 2'd1, 32'd1);
        seen0 = req_seen;
        idle(140);
        chk("R5", "request after kick", 32'(req_seen - seen0), 32'd1);
        // R4: run cleared in stage B, request still on time
        wr(2'd1, 32'd3);
        wr(2'd0, cw(0, 3, 0, 1, 2));
        wr(2'd0, cw(1, 3, 0, 1, 2));
        idle(40);
        wr(2'd0, cw(0, 3, 0, 1, 2));
        seen0 = req_seen;
        idle(80);
        chk("R4", "request despite stop", 32'(req_seen - seen0), 32'd1);

        // R7: warm reset keeps flag B
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        rd("R7", 2'd1, 32'd2);
        rd("R7", 2'd0, 32'd0);

        // R11: kick while idle
        wr(2'd2, 32'd1);
        idle(60);
        rd("R11", 2'd1, 32'd2);
        chk("R11", "no request", {31'd0, rst_req}, 32'd0);

        // R7 R10: full reset clears flag B
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R7", 2'd1, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog expired, act=%0d exp<150000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule